// File: doc/BRIEF.md
# Transmit Symbol Buffer with Frame Ramp Interlock

The block sits between a host that writes transmit data words and a modulator that takes one symbol per symbol strobe. Each host word carries a 2-bit symbol and a ramp flag. The words are held in a first-in first-out store of parameterized depth. On each strobe the oldest stored symbol is released, and the output keeps that symbol until the next strobe.

The ramp flag acts as a frame interlock. A controller with five states (idle, ramping up, active, ramping down, done) uses it to decide which words are stored. It also drives the ramp-up and ramp-down requests to a power controller. Each ramp lasts a parameterized number of symbol strobes. Two level flags warn the host when the store is nearly empty or nearly full. Two sticky flags record an underrun and an overflow.

Top module: `tsf_tx_symbol_fifo`

## Requirements
- R1: While reset is high, and in the cycle after it is released, every output is 0: `sym_out` is 2'b00 and every flag and request is low.
- R2: Stored symbols come out in the order they were written. A strobe with at least one word stored loads the oldest word into `sym_out` on that clock edge. `sym_out` does not change in any cycle that follows a cycle with no strobe.
- R3: `nearly_empty_o` is high exactly when one word is stored. It follows the stored count as that count stands after each clock edge.
- R4: `nearly_full_o` is high exactly when DEPTH-1 words are stored (15 by default).
- R5: In the idle or done state, a write with `wr_ramp`=1 is stored and starts a frame. `ramp_up_o` is high from the next cycle. It stays high until RAMP_LEN strobes have arrived in the ramping-up state. The frame is then active, and neither request is high.
- R6: In the idle or done state, a write with `wr_ramp`=0 is ignored. Nothing is stored and no flag changes.
- R7: In the ramping-up or active state, a write with `wr_ramp`=0 is stored and ends the frame. `ramp_dn_o` is high from the next cycle until RAMP_LEN strobes have arrived in the ramping-down state. The block then enters the done state.
- R8: In the ramping-down state, every write is stored as a valid symbol. This applies to writes with the ramp flag clear.
- R9: A strobe that finds the store empty while a frame is in progress (ramping up, active or ramping down) sets the sticky flag `underrun_o`. `sym_out` keeps its last value.
- R10: A write that the interlock accepts while DEPTH words are stored is discarded and sets the sticky flag `overflow_o`. Fullness is judged on the count before that clock edge. The frame state still changes as the ramp flag demands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for one data word |
| wr_sym | input | 2 | Symbol carried by the written word |
| wr_ramp | input | 1 | Ramp flag carried by the written word |
| sym_strobe | input | 1 | One-cycle symbol-rate strobe from the modulator |
| sym_out | output | 2 | Symbol currently presented to the modulator |
| ramp_up_o | output | 1 | Ramp-up request to the power controller |
| ramp_dn_o | output | 1 | Ramp-down request to the power controller |
| nearly_empty_o | output | 1 | High when exactly one word is stored |
| nearly_full_o | output | 1 | High when exactly one free location remains |
| underrun_o | output | 1 | Sticky: a strobe found the store empty during a frame |
| overflow_o | output | 1 | Sticky: an accepted write arrived while the store was full |

## Verification
The assertions assume that every input is synchronous to the clock and has a known value whenever reset is low. They also assume that a ramp request can begin only in response to a host write in the cycle before. The bench meets both conditions by driving all inputs on the falling edge from a fixed-seed generator. It also keeps the bits of `wr_sym` and `wr_ramp` defined even in cycles where `wr_en` is low. In the random phase, the ramp flag follows a modeled host intent that flips now and then. This yields frames that follow the protocol as well as stray writes that break it, so the stream covers every interlock state.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [2:0] {
    FR_IDLE    = 3'd0,
    FR_RAMP_UP = 3'd1,
    FR_ACTIVE  = 3'd2,
    FR_RAMP_DN = 3'd3,
    FR_DONE    = 3'd4
  } frame_st_t;
endpackage

// File: rtl/tsf_frame_ctl.sv
module tsf_frame_ctl
  import tsf_pkg::*;
#(
  parameter int RAMP_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_ramp,
  input  logic sym_strobe,
  output logic wr_pass,
  output logic frame_live,
  output logic ramp_up_o,
  output logic ramp_dn_o
);
  localparam int CW = (RAMP_LEN > 1) ? $clog2(RAMP_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RAMP_LEN - 1);

  frame_st_t st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  // writes pass the interlock inside a frame, or when they open one
  assign frame_live = (st_q == FR_RAMP_UP) || (st_q == FR_ACTIVE) || (st_q == FR_RAMP_DN);
  assign wr_pass    = wr_en && (frame_live || wr_ramp);
  assign ramp_up_o  = (st_q == FR_RAMP_UP);
  assign ramp_dn_o  = (st_q == FR_RAMP_DN);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      FR_IDLE, FR_DONE: begin
        if (wr_en && wr_ramp) begin
          st_n  = FR_RAMP_UP;
          cnt_n = '0;
        end
      end
      FR_RAMP_UP: begin
        if (wr_en && !wr_ramp) begin
          st_n  = FR_RAMP_DN;
          cnt_n = '0;
        end else if (sym_strobe) begin
          if (cnt_q == LAST) begin
            st_n  = FR_ACTIVE;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      FR_ACTIVE: begin
        if (wr_en && !wr_ramp) begin
          st_n  = FR_RAMP_DN;
          cnt_n = '0;
        end
      end
      FR_RAMP_DN: begin
        if (sym_strobe) begin
          if (cnt_q == LAST) begin
            st_n  = FR_DONE;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        st_n  = FR_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/tsf_fifo.sv
module tsf_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_req,
  input  logic [W-1:0] din,
  input  logic         strobe,
  input  logic         frame_live,
  output logic [W-1:0] dout,
  output logic         nearly_empty,
  output logic         nearly_full,
  output logic         underrun,
  output logic         overflow
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] C_FULL   = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] C_NFULL  = CNTW'(DEPTH - 1);
  localparam logic [CNTW-1:0] C_ONE    = CNTW'(1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            full, empty, do_push, do_pop;

  assign full    = (cnt_q == C_FULL);
  assign empty   = (cnt_q == '0);
  assign do_push = push_req && !full;
  assign do_pop  = strobe && !empty;
  assign cnt_n   = cnt_q + CNTW'(do_push) - CNTW'(do_pop);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (do_pop) begin
      dout <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      cnt_q        <= '0;
      nearly_empty <= 1'b0;
      nearly_full  <= 1'b0;
      underrun     <= 1'b0;
      overflow     <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      cnt_q        <= cnt_n;
      nearly_empty <= (cnt_n == C_ONE);
      nearly_full  <= (cnt_n == C_NFULL);
      if (strobe && empty && frame_live) underrun <= 1'b1;
      if (push_req && full)              overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/tsf_tx_symbol_fifo.sv
module tsf_tx_symbol_fifo #(
  parameter int DEPTH    = 16,
  parameter int RAMP_LEN = 4,
  parameter int SYM_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SYM_W-1:0] wr_sym,
  input  logic             wr_ramp,
  input  logic             sym_strobe,
  output logic [SYM_W-1:0] sym_out,
  output logic             ramp_up_o,
  output logic             ramp_dn_o,
  output logic             nearly_empty_o,
  output logic             nearly_full_o,
  output logic             underrun_o,
  output logic             overflow_o
);
  logic wr_pass, frame_live;

  tsf_frame_ctl #(.RAMP_LEN(RAMP_LEN)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_ramp    (wr_ramp),
    .sym_strobe (sym_strobe),
    .wr_pass    (wr_pass),
    .frame_live (frame_live),
    .ramp_up_o  (ramp_up_o),
    .ramp_dn_o  (ramp_dn_o)
  );

  tsf_fifo #(.DEPTH(DEPTH), .W(SYM_W)) u_fifo (
    .clk          (clk),
    .rst          (rst),
    .push_req     (wr_pass),
    .din          (wr_sym),
    .strobe       (sym_strobe),
    .frame_live   (frame_live),
    .dout         (sym_out),
    .nearly_empty (nearly_empty_o),
    .nearly_full  (nearly_full_o),
    .underrun     (underrun_o),
    .overflow     (overflow_o)
  );
endmodule

// File: rtl/tsf_tx_symbol_fifo_chk.sv
module tsf_tx_symbol_fifo_chk #(
  parameter int SYM_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [SYM_W-1:0] wr_sym,
  input logic             wr_ramp,
  input logic             sym_strobe,
  input logic [SYM_W-1:0] sym_out,
  input logic             ramp_up_o,
  input logic             ramp_dn_o,
  input logic             nearly_empty_o,
  input logic             nearly_full_o,
  input logic             underrun_o,
  input logic             overflow_o
);
  // R2: output only moves after a strobe
  p_hold_sym_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(sym_strobe) |-> $stable(sym_out));

  // R3/R4: a count cannot be both one and DEPTH-1
  p_level_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(nearly_empty_o && nearly_full_o));

  // R5: ramp-up begins only after a write with the flag set
  p_up_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ramp_up_o) |-> $past(wr_en && wr_ramp));

  // R7: ramp-down begins only after a write with the flag clear
  p_dn_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ramp_dn_o) |-> $past(wr_en && !wr_ramp));

  // R5/R7: the two requests never overlap
  p_ramp_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(ramp_up_o && ramp_dn_o));

  // R9: underrun is sticky and needs a strobe to appear
  p_under_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    underrun_o |=> underrun_o);
  p_under_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun_o) |-> $past(sym_strobe));

  // R10: overflow is sticky and needs a write to appear
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);
  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow_o) |-> $past(wr_en));
endmodule

bind tsf_tx_symbol_fifo tsf_tx_symbol_fifo_chk #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/tb_tsf_tx_symbol_fifo.sv
`timescale 1ns/1ps
module tb_tsf_tx_symbol_fifo;
  localparam int DEPTH = 16;
  localparam int RL    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_ramp = 1'b0, sym_strobe = 1'b0;
  logic [1:0] wr_sym = 2'b00;
  logic [1:0] sym_out;
  logic ramp_up_o, ramp_dn_o, nearly_empty_o, nearly_full_o, underrun_o, overflow_o;

  always #2 clk = ~clk;

  tsf_tx_symbol_fifo #(.DEPTH(DEPTH), .RAMP_LEN(RL), .SYM_W(2)) dut (.*);

  int n_tests = 0, n_fail = 0;

  // reference model; states 0 idle,1 up,2 active,3 down,4 done
  logic [1:0] mq[$];
  int  ms, mcnt;
  logic [1:0] msym;
  bit  mund, movf;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mq.delete(); ms = 0; mcnt = 0; msym = 0; mund = 0; movf = 0;
  endtask

  task automatic compare_all();
    chk("R2 sym_out", sym_out, msym);
    chk("R3 nearly_empty", nearly_empty_o, mq.size() == 1);
    chk("R4 nearly_full", nearly_full_o, mq.size() == DEPTH-1);
    chk("R5 ramp_up", ramp_up_o, ms == 1);
    chk("R7 ramp_dn", ramp_dn_o, ms == 3);
    chk("R9 underrun", underrun_o, mund);
    chk("R10 overflow", overflow_o, movf);
  endtask

  task automatic step(input bit we, input bit [1:0] s, input bit r, input bit st);
    bit inf, pass;
    int sz;
    @(negedge clk);
    wr_en = we; wr_sym = s; wr_ramp = r; sym_strobe = st;
    inf  = (ms == 1) || (ms == 2) || (ms == 3);
    pass = we && (inf || r);
    sz   = mq.size();
    if (st && sz > 0) msym = mq.pop_front();
    else if (st && inf) mund = 1;
    if (pass) begin
      if (sz == DEPTH) movf = 1;
      else mq.push_back(s);
    end
    case (ms)
      0, 4: if (we && r) begin ms = 1; mcnt = 0; end
      1: if (we && !r) begin ms = 3; mcnt = 0; end
         else if (st) begin
           if (mcnt == RL-1) begin ms = 2; mcnt = 0; end else mcnt++;
         end
      2: if (we && !r) begin ms = 3; mcnt = 0; end
      3: if (st) begin
           if (mcnt == RL-1) begin ms = 4; mcnt = 0; end else mcnt++;
         end
      default: ms = 0;
    endcase
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_en = 0; sym_strobe = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    @(posedge clk); #1;
    // R1: all outputs clear after reset
    chk("R1 sym_out", sym_out, 0);
    chk("R1 flags", {ramp_up_o, ramp_dn_o, nearly_empty_o, nearly_full_o, underrun_o, overflow_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit intent;
    void'($urandom(32'd2024));
    model_reset();
    do_reset();

    // R6: flag-clear write while idle is dropped
    step(1, 2'd3, 0, 0);
    chk("R6 idle write stored", nearly_empty_o, 0);
    step(0, 0, 0, 1);
    chk("R6 idle sym_out", sym_out, 0);

    // R5: open a frame and fill to the top
    step(1, 2'd1, 1, 0);
    chk("R5 ramp_up after start", ramp_up_o, 1);
    for (int i = 0; i < DEPTH-1; i++) step(1, 2'(i), 1, 0);
    chk("R10 full no overflow yet", overflow_o, 0);
    step(1, 2'd2, 1, 0);
    chk("R10 overflow on full write", overflow_o, 1);

    // R2: drain in order, ramp-up completes after RL strobes
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 1);
    chk("R5 ramp_up ended", ramp_up_o, 0);
    // R9: empty strobe inside the frame
    step(0, 0, 1, 1);
    chk("R9 underrun set", underrun_o, 1);

    // R7 and R8
    step(1, 2'd2, 0, 0);
    chk("R7 ramp_dn after clear flag", ramp_dn_o, 1);
    step(0, 0, 0, 1);
    step(1, 2'd3, 0, 0);
    chk("R8 ramp-down write stored", nearly_empty_o, 1);
    step(0, 0, 0, 1);
    chk("R8 ramp-down symbol out", sym_out, 3);
    for (int i = 0; i < RL; i++) step(0, 0, 0, 1);
    chk("R7 ramp_dn ended", ramp_dn_o, 0);
    step(1, 2'd1, 0, 0);
    chk("R6 done write stored", nearly_empty_o, 0);

    // random phase
    do_reset();
    intent = 0;
    for (int i = 0; i < 6000; i++) begin
      int rv;
      rv = $urandom;
      if ((rv & 32'h3f) == 0) intent = ~intent;
      step(rv[8:7] != 0 && rv[12:9] < 4'd7, rv[14:13],
           (rv[20:16] == 0) ? ~intent : intent, rv[25:24] == 0);
      if (i == 3000) begin
        do_reset();
        intent = 0;
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule